// File: doc/BRIEF.md
# Page-Aware Store Buffer

This block sits between a processor's write-through store path and main memory. Each store that the processor issues is placed in a small first-in first-out queue, and the processor goes on running while the queue empties to memory in the background. The processor is held back only when every slot is taken and no slot frees up in that same cycle.

The drain rate depends on page locality. The memory behind the buffer can complete a write to the page it last wrote in a single cycle. A write to any other page, and the first write after reset, takes a longer parameterised time, which is 5 cycles by default. So a run of stores to one page drains at one per cycle and the processor sees no stall. Stores that jump between pages fill the queue and then hold the processor back. Depth, page size and the slow latency are parameters, so the same code can be built as a small slow buffer or as a deeper buffer that drains quickly in page mode.

Processor loads are checked against the queue. A load whose address equals a queued store gets the data of the newest such store. A load that matches no store exactly but falls in the same cache line as a queued store is told to wait until that store has drained. Any other load may go to memory at once.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty, no stall and no memory write are signalled, and no page counts as recently written, so the first write after reset takes the slow latency.
- R2: While the queue holds fewer than DEPTH entries, a store offered with `st_valid` is accepted in that cycle and `st_stall` is low.
- R3: With DEPTH entries queued and no retirement in the cycle, `st_stall` is high and the offered store is not taken; the queue never holds more than DEPTH entries.
- R4: With DEPTH entries queued and an entry retiring in the same cycle, `st_stall` is low and the offered store is accepted.
- R5: Stores reach memory in the exact order they were accepted, and `mem_addr` and `mem_data` carry the address and data of the retiring store while `mem_we` is high.
- R6: When the head entry lies in the same page as the previously retired write, it retires in its first cycle at the head of the queue.
- R7: When the head entry lies in a different page, or no write has retired since reset, it retires after SLOW_LAT cycles at the head.
- R8: The page of an address is its bits from PAGE_BITS upward (bits 31 to 12 by default), so addresses that differ only below bit PAGE_BITS share a page.
- R9: A load with `ld_valid` whose address equals one or more queued stores raises `ld_fwd` in the same cycle, and `ld_data` carries the data of the newest of them.
- R10: A load that matches no queued store exactly but shares address bits from LINE_BITS upward (bits 31 to 4 by default) with a queued store raises `ld_wait`. With no such store, both `ld_fwd` and `ld_wait` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor offers a store this cycle |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_stall | output | 1 | Store not taken this cycle; processor holds it |
| ld_valid | input | 1 | Processor issues a load this cycle |
| ld_addr | input | 32 | Load byte address |
| ld_fwd | output | 1 | Load served from the queue |
| ld_data | output | 32 | Forwarded data (zero when `ld_fwd` is low) |
| ld_wait | output | 1 | Load must wait for a same-line store to drain |
| mem_we | output | 1 | A store retires to memory this cycle |
| mem_addr | output | 32 | Address of the retiring store |
| mem_data | output | 32 | Data of the retiring store |

## Verification
The hardest case to reach is a store that arrives in the very cycle a full queue lets its head go. It only occurs when the queue fills while a slow write is at its head and that write's last wait cycle lines up with a waiting store. The stimulus gets there with streams that alternate between two pages, so every retirement is slow and the processor is always waiting. Seeded random traffic over two pages adds many more such alignments. Forwarding of the newest of several copies needs duplicate addresses in the queue at once, so loads are issued while two stores to one address sit behind a slow head, together with a same-line load and an unrelated load.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int WB_AW = 32;
    localparam int WB_DW = 32;

    typedef struct packed {
        logic [WB_AW-1:0] addr;
        logic [WB_DW-1:0] data;
    } wb_ent_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  wb_ent_t         push_ent,
    output wb_ent_t         ord [DEPTH],
    output logic [DEPTH-1:0] live,
    output logic [CW-1:0]   occ,
    output logic            full,
    output logic            empty
);
    typedef struct packed {
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] occ;
    } st_t;

    st_t     s_q, s_d;
    wb_ent_t mem_q [DEPTH];
    logic [PW-1:0] wr_idx;

    function automatic logic [PW-1:0] wrap(input int v);
        return PW'(v % DEPTH);
    endfunction

    always_comb begin
        s_d    = s_q;
        wr_idx = wrap(32'(s_q.rd_ptr) + 32'(s_q.occ));
        if (pop) begin
            s_d.rd_ptr = wrap(32'(s_q.rd_ptr) + 1);
        end
        s_d.occ = s_q.occ + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_idx] <= push_ent;
        end
    end

    // Present the queue oldest first so the lookup can rank matches by age.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ord
        assign ord[i]  = mem_q[wrap(32'(s_q.rd_ptr) + i)];
        assign live[i] = (CW'(i) < s_q.occ);
    end

    assign occ   = s_q.occ;
    assign full  = (s_q.occ == CW'(DEPTH));
    assign empty = (s_q.occ == '0);
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int SLOW_LAT  = 5,
    localparam int PGW = WB_AW - PAGE_BITS,
    localparam int TW  = $clog2(SLOW_LAT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           have,
    input  logic [PGW-1:0] head_page,
    output logic           retire
);
    typedef struct packed {
        logic [TW-1:0]  waited;
        logic [PGW-1:0] pg;
        logic           pg_vld;
    } st_t;

    st_t s_q, s_d;
    logic          same_page;
    logic [TW-1:0] need;

    always_comb begin
        s_d       = s_q;
        same_page = s_q.pg_vld && (head_page == s_q.pg);
        need      = same_page ? TW'(1) : TW'(SLOW_LAT);
        retire    = have && ((s_q.waited + TW'(1)) >= need);
        if (retire) begin
            s_d.waited = '0;
            s_d.pg     = head_page;
            s_d.pg_vld = 1'b1;
        end else if (have) begin
            s_d.waited = s_q.waited + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup
    import wbuf_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int LINE_BITS = 4
) (
    input  logic             ld_valid,
    input  logic [WB_AW-1:0] ld_addr,
    input  wb_ent_t          ord [DEPTH],
    input  logic [DEPTH-1:0] live,
    output logic             ld_fwd,
    output logic [WB_DW-1:0] ld_data,
    output logic             ld_wait
);
    logic             hit;
    logic             line_hit;
    logic [WB_DW-1:0] hit_data;

    always_comb begin
        hit      = 1'b0;
        line_hit = 1'b0;
        hit_data = '0;
        // Scan oldest to newest; a later match overrides an earlier one.
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i]) begin
                if (ord[i].addr == ld_addr) begin
                    hit      = 1'b1;
                    hit_data = ord[i].data;
                end
                if (ord[i].addr[WB_AW-1:LINE_BITS] == ld_addr[WB_AW-1:LINE_BITS]) begin
                    line_hit = 1'b1;
                end
            end
        end
        ld_fwd  = ld_valid && hit;
        ld_wait = ld_valid && !hit && line_hit;
        ld_data = ld_fwd ? hit_data : '0;
    end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int PAGE_BITS = 12,
    parameter int LINE_BITS = 4,
    parameter int SLOW_LAT  = 5,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [WB_AW-1:0] st_addr,
    input  logic [WB_DW-1:0] st_data,
    output logic             st_stall,
    input  logic             ld_valid,
    input  logic [WB_AW-1:0] ld_addr,
    output logic             ld_fwd,
    output logic [WB_DW-1:0] ld_data,
    output logic             ld_wait,
    output logic             mem_we,
    output logic [WB_AW-1:0] mem_addr,
    output logic [WB_DW-1:0] mem_data
);
    wb_ent_t          ord [DEPTH];
    wb_ent_t          in_ent;
    logic [DEPTH-1:0] live;
    logic [CW-1:0]    occ;
    logic             full;
    logic             empty;
    logic             retire;
    logic             push;

    assign in_ent   = '{addr: st_addr, data: st_data};
    assign st_stall = full && !retire;
    assign push     = st_valid && !st_stall;

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (retire),
        .push_ent (in_ent),
        .ord      (ord),
        .live     (live),
        .occ      (occ),
        .full     (full),
        .empty    (empty)
    );

    wbuf_drain #(.PAGE_BITS(PAGE_BITS), .SLOW_LAT(SLOW_LAT)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .have      (!empty),
        .head_page (ord[0].addr[WB_AW-1:PAGE_BITS]),
        .retire    (retire)
    );

    wbuf_lookup #(.DEPTH(DEPTH), .LINE_BITS(LINE_BITS)) u_lookup (
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ord      (ord),
        .live     (live),
        .ld_fwd   (ld_fwd),
        .ld_data  (ld_data),
        .ld_wait  (ld_wait)
    );

    assign mem_we   = retire;
    assign mem_addr = retire ? ord[0].addr : '0;
    assign mem_data = retire ? ord[0].data : '0;
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
    parameter int DEPTH = 6,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_stall,
    input logic [CW-1:0] occ,
    input logic          mem_we,
    input logic          ld_fwd,
    input logic          ld_wait
);
    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R3: a stall is only raised with every slot taken
    a_r3_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (occ == CW'(DEPTH)));

    // R4: a retiring cycle never stalls the processor
    a_r4_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !st_stall);

    // R2: an accepted store with nothing retiring grows the queue by one
    a_r2_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_stall && !mem_we) |=> (occ == $past(occ) + CW'(1)));

    // R1: an empty queue writes nothing to memory
    a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !mem_we);

    // R10: a load is never both forwarded and told to wait
    a_r10_fwd_wait_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_fwd && ld_wait));
endmodule

bind wbuf_top wbuf_checker #(.DEPTH(DEPTH)) u_wbuf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_stall (st_stall),
    .occ      (occ),
    .mem_we   (mem_we),
    .ld_fwd   (ld_fwd),
    .ld_wait  (ld_wait)
);

// File: tb/tb_wbuf_top.sv
`timescale 1ns/1ps
module tb_wbuf_top;
    import wbuf_pkg::*;

    localparam int DEPTH     = 6;
    localparam int PAGE_BITS = 12;
    localparam int LINE_BITS = 4;
    localparam int SLOW_LAT  = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             st_valid;
    logic [WB_AW-1:0] st_addr;
    logic [WB_DW-1:0] st_data;
    logic             st_stall;
    logic             ld_valid;
    logic [WB_AW-1:0] ld_addr;
    logic             ld_fwd;
    logic [WB_DW-1:0] ld_data;
    logic             ld_wait;
    logic             mem_we;
    logic [WB_AW-1:0] mem_addr;
    logic [WB_DW-1:0] mem_data;

    always #2 clk = ~clk;

    wbuf_top #(.DEPTH(DEPTH), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS),
               .SLOW_LAT(SLOW_LAT)) dut (.*);

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
    } ment_t;

    ment_t m_q[$];
    int    m_wait;
    logic [31:0] m_pg;
    bit    m_pg_vld;
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One clock: compare outputs with the model, then advance the model.
    task automatic one_cycle(output bit accepted);
        bit e_ret, e_stall, e_fwd, e_wait, same;
        logic [31:0] e_fd;
        int lat;
        #1;
        same    = (m_q.size() > 0) && m_pg_vld && ((m_q[0].a >> PAGE_BITS) == m_pg);
        lat     = same ? 1 : SLOW_LAT;
        e_ret   = (m_q.size() > 0) && (m_wait + 1 >= lat);
        e_stall = (m_q.size() == DEPTH) && !e_ret;
        e_fwd   = 0;
        e_wait  = 0;
        e_fd    = '0;
        if (ld_valid) begin
            foreach (m_q[i]) if (m_q[i].a == ld_addr) begin
                e_fwd = 1;
                e_fd  = m_q[i].d;
            end
            if (!e_fwd) foreach (m_q[i])
                if ((m_q[i].a >> LINE_BITS) == (ld_addr >> LINE_BITS)) e_wait = 1;
        end
        chk(st_stall === e_stall, (m_q.size() == DEPTH && e_ret) ? "R4" : "R2 R3",
            "st_stall", 32'(st_stall), 32'(e_stall));
        chk(mem_we === e_ret, same ? "R6 R8" : "R7 R1", "mem_we", 32'(mem_we), 32'(e_ret));
        if (e_ret) begin
            chk(mem_addr === m_q[0].a, "R5", "mem_addr", mem_addr, m_q[0].a);
            chk(mem_data === m_q[0].d, "R5", "mem_data", mem_data, m_q[0].d);
        end
        chk(ld_fwd === e_fwd, "R9", "ld_fwd", 32'(ld_fwd), 32'(e_fwd));
        if (e_fwd) chk(ld_data === e_fd, "R9", "ld_data", ld_data, e_fd);
        chk(ld_wait === e_wait, "R10", "ld_wait", 32'(ld_wait), 32'(e_wait));
        accepted = st_valid && !e_stall;
        @(posedge clk);
        if (e_ret) begin
            m_pg     = m_q[0].a >> PAGE_BITS;
            m_pg_vld = 1;
            void'(m_q.pop_front());
            m_wait = 0;
        end else if (m_q.size() > 0) begin
            m_wait++;
        end
        if (accepted) m_q.push_back('{a: st_addr, d: st_data});
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", "cycle limit", 32'(cycles), 32'd150000);
            finish_run();
        end
        @(negedge clk);
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d);
        bit acc;
        st_valid = 1;
        st_addr  = a;
        st_data  = d;
        acc      = 0;
        while (!acc) one_cycle(acc);
        st_valid = 0;
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int k = 0; k < n; k++) one_cycle(acc);
    endtask

    task automatic load_cycle(input logic [31:0] a);
        bit acc;
        ld_valid = 1;
        ld_addr  = a;
        one_cycle(acc);
        ld_valid = 0;
    endtask

    initial begin
        #(4 * 180000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit acc;
        rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0; ld_valid = 0; ld_addr = '0;
        m_wait = 0; m_pg = '0; m_pg_vld = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state at the ports
        chk(st_stall === 1'b0, "R1", "st_stall after reset", 32'(st_stall), 0);
        chk(mem_we === 1'b0, "R1", "mem_we after reset", 32'(mem_we), 0);
        chk(ld_fwd === 1'b0 && ld_wait === 1'b0, "R1", "load flags after reset",
            32'({ld_fwd, ld_wait}), 0);
        @(negedge clk);

        // R1/R7: first write after reset takes the slow latency
        store(32'h0000_1000, 32'hA000_0001);
        idle(8);

        // R6/R8: same-page burst, offsets below bit 12 only
        for (int k = 0; k < 14; k++) store(32'h0000_2000 + 32'(k * 4 * 37 % 4096), 32'hB000_0000 + 32'(k));
        idle(10);

        // R3/R4: alternating pages fill the queue and stall
        for (int k = 0; k < 14; k++) store((k % 2 == 0) ? 32'h0000_3000 : 32'h0000_5000 + 32'(k * 4),
                                           32'hC000_0000 + 32'(k));
        idle(40);

        // R9/R10: duplicates in the queue behind a slow head
        store(32'h0001_6000, 32'hD000_0001);
        store(32'h0001_6000, 32'hD000_0002);
        store(32'h0001_6004, 32'hD000_0003);
        store(32'h0001_7000, 32'hD000_0004);
        load_cycle(32'h0001_6000);
        load_cycle(32'h0001_6008);
        load_cycle(32'h0001_7000);
        load_cycle(32'h0002_0000);
        load_cycle(32'h0001_7004);
        idle(40);

        // Mixed random traffic over two pages
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ld_valid = lfsr[3];
            ld_addr  = (lfsr[9] ? 32'h0000_9000 : 32'h0000_8000) + {26'd0, lfsr[14:12], 2'b00};
            if (lfsr[5] | lfsr[6]) begin
                st_valid = 1;
                st_addr  = (lfsr[7] & lfsr[8] ? 32'h0000_9000 : 32'h0000_8000) + {26'd0, lfsr[18:16], 2'b00};
                st_data  = lfsr ^ 32'h5A5A_0000;
                acc = 0;
                while (!acc) one_cycle(acc);
                st_valid = 0;
            end else begin
                one_cycle(acc);
            end
        end
        ld_valid = 0;
        idle(60);
        finish_run();
    end
endmodule